// File: doc/BRIEF.md
# Continuous-Read Serial Output Interface

This block is the device-side digital serial port of a multichannel converter when it runs in continuous-read mode. The converter core delivers each finished result on a stimulus port as a single-cycle strobe with a data word and a channel number. The block drives one pin that carries both the ready indication and the data. It shifts the word out MSB first on the host serial clock. It also watches the serial input line for commands and for a long run of ones.

The host enables the mode by sending one command byte. After that it only has to supply clocks. When a result is waiting, the pin goes low. Each falling clock edge then presents the next bit. Once the last bit has been clocked, the pin returns high. A result that the host leaves unread is dropped when the next one arrives. A mode bit appends a status byte that carries the channel number. A second command byte, sent while a result is pending, leaves the mode. Forty ones in a row on the input line reset the interface to its default state.

All inputs are sampled on the system clock `clk`. The serial clock is edge-detected against its previous sample, and the output pin is registered. The serial clock must therefore stay well below `clk`.

Top module: `cread_serial_if`

## Requirements
- R1: After reset, `cread_on` is 0, `dout` is 1 and `dout_oe` is 0.
- R2: Command bytes are shifted in on rising SCLK edges while `cs_n` is low, MSB first, 8 bits per byte, with the bit count restarting whenever `cs_n` is high. The byte 0x5C received while the mode is off sets `cread_on` to 1.
- R3: In the mode, a conversion strobe makes the pin read 0 (ready) until the first falling SCLK edge of the read.
- R4: The first falling SCLK edge presents the MSB of the word, and each later falling edge presents the next bit. The data field (DATA_W bits) comes first.
- R5: The value of `status_en` at load time selects the word format. If it is 1, an 8-bit status byte follows the data: (8-CHAN_W) zero bits, then the channel number. The word is then DATA_W+8 bits long. If it is 0, the word is DATA_W bits long.
- R6: On the rising SCLK edge that takes the last bit, the pin returns to 1 and stays 1 under further clocks until the next conversion. A word can be read only once.
- R7: A conversion that arrives while a word is still unread replaces that word. The next read starts at the MSB of the new word.
- R8: The byte 0x58 received while a word is pending clears `cread_on` and drops the word, so the pin reads 1. The byte 0x58 received with no word pending leaves `cread_on` at 1.
- R9: Any 0 sampled on DIN clears the ones counter, and the counter saturates at RST_ONES (default 40). When RST_ONES consecutive 1s have been sampled, `cread_on` clears and any pending word is dropped, even in the middle of a read. With 39 ones followed by a 0, the mode stays on.
- R10: While `cs_n` is high, `dout_oe` is 0 and the bit counters are held at zero. The next read restarts at the MSB of the word still pending.
- R11: While the mode is off, conversion strobes are ignored and the pin stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | One-cycle strobe: a conversion has finished |
| conv_data | input | DATA_W | Conversion result |
| conv_chan | input | CHAN_W | Channel of the conversion |
| status_en | input | 1 | Append the status byte to each word |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Host serial clock, idle high |
| din | input | 1 | Host serial data in |
| dout | output | 1 | Combined ready / data out pin value |
| dout_oe | output | 1 | Output enable for dout (0 = high impedance) |
| cread_on | output | 1 | Continuous-read mode active |

## Verification
Reads are driven with random data words, random channels and a random status-append bit. These tell apart the two word lengths, the bit order and the channel field of the status byte. Directed patterns cover the following:
- a partial read cut off by a newer conversion, which separates replacement from continuation;
- a chip-select drop in the middle of a word, which shows that the read restarts rather than resumes;
- the exit byte sent with and without a pending word;
- 39 ones followed by a zero, against a full run of 40 ones sent during a pending word, which locates the reset threshold exactly.

// File: rtl/cread_pkg.sv
package cread_pkg;
  localparam int STAT_W = 8;
  localparam logic [7:0] CMD_ENTER = 8'h5C;
  localparam logic [7:0] CMD_LEAVE = 8'h58;

  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_ev_t;
endpackage

// File: rtl/cread_sclk_edge.sv
module cread_sclk_edge
  import cread_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sclk,
  input  logic     cs_n,
  output sclk_ev_t ev
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b1;
    else     sclk_q <= sclk;
  end

  always_comb begin
    ev.rise = !cs_n && sclk && !sclk_q;
    ev.fall = !cs_n && !sclk && sclk_q;
  end
endmodule

// File: rtl/cread_cmd_rx.sv
module cread_cmd_rx
  import cread_pkg::*;
#(
  parameter int RST_ONES = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  sclk_ev_t   ev,
  input  logic       cs_n,
  input  logic       din,
  output logic       cmd_valid,
  output logic [7:0] cmd_byte,
  output logic       ones_reset
);
  localparam int ONES_W = $clog2(RST_ONES + 1);

  logic [2:0]        bit_cnt;
  logic [6:0]        sh;
  logic [ONES_W-1:0] ones;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      sh        <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else begin
      cmd_valid <= 1'b0;
      if (cs_n || ones_reset) begin
        bit_cnt <= '0;
      end else if (ev.rise) begin
        if (bit_cnt == 3'd7) begin
          cmd_byte  <= {sh, din};
          cmd_valid <= 1'b1;
          bit_cnt   <= '0;
        end else begin
          sh      <= {sh[5:0], din};
          bit_cnt <= bit_cnt + 3'd1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ones       <= '0;
      ones_reset <= 1'b0;
    end else begin
      ones_reset <= 1'b0;
      if (ev.rise) begin
        if (!din) begin
          ones <= '0;
        end else if (ones != ONES_W'(RST_ONES)) begin
          ones <= ones + 1'b1;
          if (ones == ONES_W'(RST_ONES - 1)) ones_reset <= 1'b1;
        end
      end
    end
  end

  assert_ones_sat_R9: assert property (@(posedge clk) disable iff (rst)
    ones <= ONES_W'(RST_ONES));

  assert_zero_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (ev.rise && !din) |=> (ones == '0));
endmodule

// File: rtl/cread_out_shift.sv
module cread_out_shift
  import cread_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_len,
  input  sclk_ev_t          ev,
  input  logic              cs_n,
  output logic              pending,
  output logic              bit_out
);
  logic [WORD_W-1:0] hold;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  len;
  logic [CNT_W-1:0]  rcnt;
  logic              started;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hold    <= '0;
      shreg   <= '0;
      len     <= '0;
      rcnt    <= '0;
      started <= 1'b0;
      pending <= 1'b0;
    end else if (load) begin
      hold    <= load_word;
      shreg   <= load_word;
      len     <= load_len;
      rcnt    <= '0;
      started <= 1'b0;
      pending <= 1'b1;
    end else if (cs_n) begin
      shreg   <= hold;
      rcnt    <= '0;
      started <= 1'b0;
    end else if (pending) begin
      if (ev.fall) begin
        if (!started) started <= 1'b1;
        else          shreg   <= {shreg[WORD_W-2:0], 1'b0};
      end
      if (ev.rise && started) begin
        if (rcnt == len - 1'b1) begin
          pending <= 1'b0;
          started <= 1'b0;
        end else begin
          rcnt <= rcnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (!pending)     bit_out = 1'b1;
    else if (started) bit_out = shreg[WORD_W-1];
    else              bit_out = 1'b0;
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    pending |-> (rcnt < len));

  assert_load_pend_R7: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> (pending && (rcnt == '0)));

  assert_cs_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cs_n && !load && !clear) |=> (rcnt == '0 && !started));
endmodule

// File: rtl/cread_serial_if.sv
module cread_serial_if
  import cread_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int CHAN_W   = 3,
  parameter int RST_ONES = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_valid,
  input  logic [DATA_W-1:0] conv_data,
  input  logic [CHAN_W-1:0] conv_chan,
  input  logic              status_en,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  output logic              cread_on
);
  localparam int WORD_W = DATA_W + STAT_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  sclk_ev_t          ev;
  logic              cmd_valid;
  logic [7:0]        cmd_byte;
  logic              ones_reset;
  logic              pend;
  logic              bit_out;
  logic              exit_fire;
  logic              clear;
  logic              load;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  wlen;
  logic [STAT_W-1:0] status;

  cread_sclk_edge u_edge (
    .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .ev(ev)
  );

  cread_cmd_rx #(.RST_ONES(RST_ONES)) u_cmd (
    .clk(clk), .rst(rst), .ev(ev), .cs_n(cs_n), .din(din),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .ones_reset(ones_reset)
  );

  always_comb begin
    status = '0;
    status[CHAN_W-1:0] = conv_chan;
    if (status_en) begin
      word = {conv_data, status};
      wlen = CNT_W'(WORD_W);
    end else begin
      word = {conv_data, {STAT_W{1'b0}}};
      wlen = CNT_W'(DATA_W);
    end
  end

  assign exit_fire = cread_on && cmd_valid && (cmd_byte == CMD_LEAVE) && pend;
  assign clear     = ones_reset || exit_fire;
  assign load      = conv_valid && cread_on && !clear;

  cread_out_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .clear(clear), .load(load),
    .load_word(word), .load_len(wlen), .ev(ev), .cs_n(cs_n),
    .pending(pend), .bit_out(bit_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cread_on <= 1'b0;
    end else if (clear) begin
      cread_on <= 1'b0;
    end else if (cmd_valid && !cread_on && cmd_byte == CMD_ENTER) begin
      cread_on <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b1;
      dout_oe <= 1'b0;
    end else begin
      dout    <= bit_out;
      dout_oe <= !cs_n;
    end
  end

  assert_exit_R8: assert property (@(posedge clk) disable iff (rst)
    exit_fire |=> (!cread_on && !pend));

  assert_ones_reset_R9: assert property (@(posedge clk) disable iff (rst)
    ones_reset |=> (!cread_on && !pend));

  assert_cs_tristate_R10: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !dout_oe);

  assert_ignore_off_R11: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && !cread_on) |=> !pend);

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
    !pend |=> dout);
endmodule

// File: tb/cread_serial_if_test.sv
module cread_serial_if_test;
  localparam int CLK_P  = 10;
  localparam int HALF   = 4;
  localparam int DATA_W = 24;
  localparam int CHAN_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_valid = 1'b0;
  logic [DATA_W-1:0] conv_data = '0;
  logic [CHAN_W-1:0] conv_chan = '0;
  logic status_en = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b1;
  logic din = 1'b0;
  logic dout, dout_oe, cread_on;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  cread_serial_if #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .RST_ONES(40)) uut (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_data(conv_data),
    .conv_chan(conv_chan), .status_en(status_en), .cs_n(cs_n), .sclk(sclk),
    .din(din), .dout(dout), .dout_oe(dout_oe), .cread_on(cread_on)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] exp_word(logic [DATA_W-1:0] d,
                                           logic [CHAN_W-1:0] c, logic st);
    return st ? {d, 5'b0, c} : {8'h00, d};
  endfunction

  function automatic int exp_len(logic st);
    return st ? 32 : 24;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bit(logic d, output logic o);
    @(negedge clk);
    sclk = 1'b0;
    din  = d;
    wait_n(HALF);
    o    = dout;
    sclk = 1'b1;
    wait_n(HALF);
  endtask

  task automatic xfer_bits(int n, logic [63:0] pattern, output logic [63:0] rd);
    logic b;
    rd = '0;
    for (int i = n - 1; i >= 0; i--) begin
      xfer_bit(pattern[i], b);
      rd = {rd[62:0], b};
    end
  endtask

  task automatic set_cs(logic v);
    @(negedge clk);
    cs_n = v;
    wait_n(3);
  endtask

  task automatic cs_cycle();
    set_cs(1'b1);
    set_cs(1'b0);
  endtask

  task automatic convert(logic [DATA_W-1:0] d, logic [CHAN_W-1:0] c, logic st);
    @(negedge clk);
    conv_valid = 1'b1;
    conv_data  = d;
    conv_chan  = c;
    status_en  = st;
    @(negedge clk);
    conv_valid = 1'b0;
    wait_n(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [31:0] ew;
    logic [DATA_W-1:0] d;
    logic [CHAN_W-1:0] c;
    logic st;
    int n;
    void'($urandom(32'h5eed_1234));

    wait_n(5);
    @(negedge clk);
    rst = 1'b0;
    wait_n(2);
    check("R1 cread_on", cread_on, 0);
    check("R1 dout", dout, 1);
    check("R1 dout_oe", dout_oe, 0);

    set_cs(1'b0);
    check("R10 oe with cs low", dout_oe, 1);
    convert(24'h123456, 3'd1, 1'b0);
    check("R11 no ready while off", dout, 1);
    xfer_bits(8, 64'h00, rd);
    check("R11 reads ones while off", rd, 64'hFF);
    cs_cycle();

    xfer_bits(8, 64'h5C, rd);
    wait_n(2);
    check("R2 enter", cread_on, 1);
    cs_cycle();

    xfer_bits(8, 64'h58, rd);
    wait_n(2);
    check("R8 exit ignored without word", cread_on, 1);
    cs_cycle();

    convert(24'hA5C3F0, 3'd5, 1'b1);
    check("R3 ready low", dout, 0);
    xfer_bits(32, 64'h0, rd);
    check("R4 R5 word with status", rd, 64'(exp_word(24'hA5C3F0, 3'd5, 1'b1)));
    wait_n(2);
    check("R6 high after read", dout, 1);
    xfer_bits(8, 64'h0, rd);
    check("R6 read once", rd, 64'hFF);
    cs_cycle();

    for (int k = 0; k < 20; k++) begin
      d  = DATA_W'($urandom);
      c  = CHAN_W'($urandom);
      st = 1'($urandom);
      ew = exp_word(d, c, st);
      n  = exp_len(st);
      convert(d, c, st);
      check("R3 ready random", dout, 0);
      xfer_bits(n, 64'h0, rd);
      check(st ? "R5 random with status" : "R4 random data only", rd, 64'(ew));
      wait_n(2);
      check("R6 random idle high", dout, 1);
      cs_cycle();
    end

    convert(24'hFFFFFF, 3'd2, 1'b1);
    xfer_bits(10, 64'h0, rd);
    check("R7 partial read", rd, 64'h3FF);
    convert(24'h0F0F0F, 3'd6, 1'b0);
    check("R7 ready for new word", dout, 0);
    xfer_bits(24, 64'h0, rd);
    check("R7 new word replaces", rd, 64'h0F0F0F);
    cs_cycle();

    convert(24'hC0FFEE, 3'd3, 1'b1);
    xfer_bits(12, 64'h0, rd);
    check("R10 first part", rd, 64'hC0F);
    set_cs(1'b1);
    check("R10 tri-state", dout_oe, 0);
    set_cs(1'b0);
    xfer_bits(32, 64'h0, rd);
    check("R10 restart at MSB", rd, 64'(exp_word(24'hC0FFEE, 3'd3, 1'b1)));
    cs_cycle();

    convert(24'h9ABCDE, 3'd4, 1'b0);
    xfer_bits(8, 64'h58, rd);
    check("R8 bits during exit", rd, 64'h9A);
    wait_n(2);
    check("R8 exit with word", cread_on, 0);
    check("R8 pin high after exit", dout, 1);
    cs_cycle();
    convert(24'h111111, 3'd0, 1'b0);
    check("R11 ignored after exit", dout, 1);

    xfer_bits(8, 64'h5C, rd);
    wait_n(2);
    check("R2 re-enter", cread_on, 1);
    cs_cycle();
    xfer_bits(40, 64'hFF_FFFF_FFFE, rd);
    wait_n(2);
    check("R9 39 ones then zero keeps mode", cread_on, 1);
    cs_cycle();
    convert(24'h00FF00, 3'd7, 1'b1);
    check("R9 ready before ones", dout, 0);
    xfer_bits(40, 64'hFF_FFFF_FFFF, rd);
    wait_n(2);
    check("R9 forty ones reset", cread_on, 0);
    check("R9 word dropped", dout, 1);
    cs_cycle();
    convert(24'h222222, 3'd1, 1'b0);
    check("R11 ignored after ones reset", dout, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule